// File: doc/BRIEF.md
# Load-Data Forwarding Operand Selector

This block chooses the two source operands for the ALU of the execute stage of a five-stage pipeline. By default each operand is the value read from the register file during decode. When the instruction now in write-back is a load whose destination register equals an execute-stage source register, that operand instead takes the loaded data register held in write-back. This lets an instruction that was held for one load-use stall cycle use the loaded value as soon as the stall ends. It does not have to wait for the register file.

An optional second path, enabled by a parameter, forwards the ALU result of the instruction in the memory stage. That producer is younger, so it wins over the write-back load data when both match. Register 0 is never forwarded. Both operands use the same rule, but their logic is independent. Each operand has a 2-bit select code that reports which source was taken. The block is purely combinational, and every result belongs to the same cycle as its inputs.

Top module: `fwd_operand_select`

## Requirements
- R1: When no forwarding condition holds for an operand, that operand equals its decode-stage register value (ex_rf_a or ex_rf_b) and its select code is 00.
- R2: When wb_instr[15:14] is 01 (a load), wb_instr[13:11] equals ex_src1, and ex_src1 is non-zero, with no memory-stage match, op_a equals wb_ldata and sel_a is 10.
- R3: Operand B applies the rule of R2 against ex_src2, independently of operand A, driving op_b and sel_b.
- R4: When wb_instr[15:14] is 00, 10 or 11, neither operand takes wb_ldata and neither select code is 10, even when wb_instr[13:11] matches a source register.
- R5: When mem_wr_en is 1 and mem_dst equals a non-zero source register, that operand equals mem_result and its select code is 01.
- R6: When the memory-stage match of R5 and the write-back load match of R2/R3 both hold for one operand, the memory-stage result is taken (select 01).
- R7: A source register number of 0 is never forwarded: the operand passes its register value with select 00, whatever the memory and write-back stages hold.
- R8: When ex_src1 equals ex_src2 and a forwarding condition holds for that register, both operands are forwarded from the same source with the same select code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src1 | input | REG_W (3) | Execute-stage source register 1 number |
| ex_src2 | input | REG_W (3) | Execute-stage source register 2 number |
| ex_rf_a | input | DATA_W (16) | Operand A value latched from the register file in decode |
| ex_rf_b | input | DATA_W (16) | Operand B value latched from the register file in decode |
| mem_wr_en | input | 1 | Memory-stage instruction writes an ALU result to a register |
| mem_dst | input | REG_W (3) | Destination register of the memory-stage instruction |
| mem_result | input | DATA_W (16) | ALU result held in the memory stage |
| wb_instr | input | INSTR_W (16) | Instruction word in the write-back stage |
| wb_ldata | input | DATA_W (16) | Loaded data register value in the write-back stage |
| op_a | output | DATA_W (16) | Selected ALU operand A |
| op_b | output | DATA_W (16) | Selected ALU operand B |
| sel_a | output | 2 | Source code for operand A: 00 register, 01 memory ALU result, 10 load data |
| sel_b | output | 2 | Source code for operand B, same coding |

## Verification
All four outputs are combinational, so each result is due in the same clock cycle as the inputs that caused it, with no latency to count. The bench applies a new input set just after each rising edge and compares op_a, op_b, sel_a and sel_b with its reference model at the following falling edge, half a period later, when the inputs are settled. Directed cycles cover each priority and corner case (register 0, shared source, non-load opcodes, both stages matching). Biased random cycles with few register numbers then produce frequent collisions between the stages.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   // Operand source codes driven on sel_a / sel_b
   typedef enum logic [1:0] {
      SEL_RF   = 2'b00,
      SEL_MEM  = 2'b01,
      SEL_LOAD = 2'b10
   } fwd_sel_e;

   // Width of the opcode class field at the top of an instruction word
   localparam int OPC_W = 2;

   // Opcode class value that marks a load instruction
   localparam logic [OPC_W-1:0] LOAD_OPC = 2'b01;

endpackage

// File: rtl/fwd_load_detect.sv
// Decodes the write-back instruction word: load class and destination field.
module fwd_load_detect
   import fwd_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int REG_W   = 3
) (
   input  logic [INSTR_W-1:0] instr,
   output logic               is_load,
   output logic [REG_W-1:0]   dst
);

   // Destination field sits right under the opcode class
   localparam int DST_LSB = INSTR_W - OPC_W - REG_W;

   if (DST_LSB < 0) begin : g_bad_layout
      $error("fwd_load_detect: INSTR_W too small for opcode and destination");
   end

   // R2 / R4: only the load opcode class qualifies
   assign is_load = (instr[INSTR_W-1 -: OPC_W] == LOAD_OPC);
   assign dst     = instr[DST_LSB +: REG_W];

   if (DST_LSB > 0) begin : g_payload
      logic unused_payload;
      assign unused_payload = ^instr[DST_LSB-1:0];
   end

endmodule

// File: rtl/fwd_src_select.sv
// One operand lane: register value, memory ALU forward, write-back load forward.
module fwd_src_select
   import fwd_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int REG_W      = 3,
   parameter bit MEM_FWD_EN = 1'b1
) (
   input  logic [REG_W-1:0]  src,
   input  logic [DATA_W-1:0] rf_val,
   input  logic              mem_wr,
   input  logic [REG_W-1:0]  mem_dst,
   input  logic [DATA_W-1:0] mem_val,
   input  logic              wb_is_load,
   input  logic [REG_W-1:0]  wb_dst,
   input  logic [DATA_W-1:0] wb_val,
   output logic [DATA_W-1:0] val,
   output logic [1:0]        sel
);

   logic     src_live;
   logic     mem_hit;
   logic     wb_hit;
   fwd_sel_e pick;

   // R7: register 0 is hard-wired and never forwarded
   assign src_live = (src != '0);

   // R2 / R3: load in write-back targeting this source
   assign wb_hit = src_live && wb_is_load && (wb_dst == src);

   if (MEM_FWD_EN) begin : g_mem_path
      // R5: memory-stage ALU result targeting this source
      assign mem_hit = src_live && mem_wr && (mem_dst == src);
   end else begin : g_no_mem_path
      logic unused_mem;
      assign unused_mem = ^{mem_wr, mem_dst, mem_val};
      assign mem_hit    = 1'b0;
   end

   // R6: younger producer (memory stage) wins over write-back load
   always_comb begin
      if (mem_hit) begin
         pick = SEL_MEM;
      end else if (wb_hit) begin
         pick = SEL_LOAD;
      end else begin
         pick = SEL_RF;
      end
   end

   always_comb begin
      unique case (pick)
         SEL_MEM:  val = mem_val;
         SEL_LOAD: val = wb_val;
         default:  val = rf_val;
      endcase
   end

   assign sel = pick;

endmodule

// File: rtl/fwd_operand_select.sv
// Execute-stage operand selector with write-back load-data forwarding.
module fwd_operand_select
   import fwd_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int REG_W      = 3,
   parameter int INSTR_W    = 16,
   parameter bit MEM_FWD_EN = 1'b1
) (
   input  logic [REG_W-1:0]   ex_src1,
   input  logic [REG_W-1:0]   ex_src2,
   input  logic [DATA_W-1:0]  ex_rf_a,
   input  logic [DATA_W-1:0]  ex_rf_b,
   input  logic               mem_wr_en,
   input  logic [REG_W-1:0]   mem_dst,
   input  logic [DATA_W-1:0]  mem_result,
   input  logic [INSTR_W-1:0] wb_instr,
   input  logic [DATA_W-1:0]  wb_ldata,
   output logic [DATA_W-1:0]  op_a,
   output logic [DATA_W-1:0]  op_b,
   output logic [1:0]         sel_a,
   output logic [1:0]         sel_b
);

   localparam int NOPS = 2;

   if (DATA_W < 1) begin : g_bad_data
      $error("fwd_operand_select: DATA_W must be positive");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("fwd_operand_select: REG_W must be positive");
   end
   if (INSTR_W < OPC_W + REG_W) begin : g_bad_instr
      $error("fwd_operand_select: INSTR_W cannot hold opcode and destination");
   end

   logic              wb_is_load;
   logic [REG_W-1:0]  wb_dst;

   logic [REG_W-1:0]  src_v [NOPS];
   logic [DATA_W-1:0] rf_v  [NOPS];
   logic [DATA_W-1:0] out_v [NOPS];
   logic [1:0]        sel_v [NOPS];

   fwd_load_detect #(
      .INSTR_W (INSTR_W),
      .REG_W   (REG_W)
   ) u_detect (
      .instr   (wb_instr),
      .is_load (wb_is_load),
      .dst     (wb_dst)
   );

   assign src_v[0] = ex_src1;
   assign src_v[1] = ex_src2;
   assign rf_v[0]  = ex_rf_a;
   assign rf_v[1]  = ex_rf_b;

   // R3 / R8: one independent lane per operand
   for (genvar i = 0; i < NOPS; i++) begin : g_lane
      fwd_src_select #(
         .DATA_W     (DATA_W),
         .REG_W      (REG_W),
         .MEM_FWD_EN (MEM_FWD_EN)
      ) u_lane (
         .src        (src_v[i]),
         .rf_val     (rf_v[i]),
         .mem_wr     (mem_wr_en),
         .mem_dst    (mem_dst),
         .mem_val    (mem_result),
         .wb_is_load (wb_is_load),
         .wb_dst     (wb_dst),
         .wb_val     (wb_ldata),
         .val        (out_v[i]),
         .sel        (sel_v[i])
      );
   end

   assign op_a  = out_v[0];
   assign op_b  = out_v[1];
   assign sel_a = sel_v[0];
   assign sel_b = sel_v[1];

endmodule

// File: rtl/fwd_operand_select_chk.sv
// Port-level checker bound to fwd_operand_select.
module fwd_operand_select_chk #(
   parameter int DATA_W  = 16,
   parameter int REG_W   = 3,
   parameter int INSTR_W = 16
) (
   input logic [REG_W-1:0]   ex_src1,
   input logic [REG_W-1:0]   ex_src2,
   input logic [DATA_W-1:0]  ex_rf_a,
   input logic [DATA_W-1:0]  ex_rf_b,
   input logic               mem_wr_en,
   input logic [REG_W-1:0]   mem_dst,
   input logic [DATA_W-1:0]  mem_result,
   input logic [INSTR_W-1:0] wb_instr,
   input logic [DATA_W-1:0]  wb_ldata,
   input logic [DATA_W-1:0]  op_a,
   input logic [DATA_W-1:0]  op_b,
   input logic [1:0]         sel_a,
   input logic [1:0]         sel_b
);

   localparam int LSB = INSTR_W - 2 - REG_W;

   logic             ld;
   logic [REG_W-1:0] wdst;

   assign ld   = (wb_instr[INSTR_W-1 -: 2] == 2'b01);
   assign wdst = wb_instr[LSB +: REG_W];

   always_comb begin
      // R1: register code passes decode values
      p_rf_pass_r1: assert ((sel_a != 2'b00 || op_a == ex_rf_a) &&
                            (sel_b != 2'b00 || op_b == ex_rf_b))
         else $error("register select without register value");
      // code 11 is never produced
      p_code_legal_r1: assert (sel_a != 2'b11 && sel_b != 2'b11)
         else $error("illegal select code");
      // R2: load code only for a matching load, carrying load data
      p_load_a_r2: assert (sel_a != 2'b10 ||
                           (ld && wdst == ex_src1 && op_a == wb_ldata))
         else $error("operand A load select unjustified");
      // R3: same for operand B
      p_load_b_r3: assert (sel_b != 2'b10 ||
                           (ld && wdst == ex_src2 && op_b == wb_ldata))
         else $error("operand B load select unjustified");
      // R4: non-load write-back never selects load data
      p_nonload_r4: assert (ld || (sel_a != 2'b10 && sel_b != 2'b10))
         else $error("load data taken for non-load");
      // R5: memory code carries memory result from a matching writer
      p_mem_val_r5: assert (sel_a != 2'b01 ||
                            (mem_wr_en && mem_dst == ex_src1 && op_a == mem_result))
         else $error("operand A memory select unjustified");
      // R6: memory match always wins
      p_mem_prio_r6: assert (!(mem_wr_en && mem_dst == ex_src1 && ex_src1 != '0) ||
                             sel_a == 2'b01)
         else $error("memory forward lost priority");
      // R7: register 0 never forwarded
      p_zero_r7: assert ((ex_src1 != '0 || sel_a == 2'b00) &&
                         (ex_src2 != '0 || sel_b == 2'b00))
         else $error("register 0 forwarded");
      // R8: shared source gives identical selection
      p_shared_r8: assert (ex_src1 != ex_src2 || sel_a == sel_b)
         else $error("shared source diverged");
   end

endmodule

bind fwd_operand_select fwd_operand_select_chk #(
   .DATA_W  (DATA_W),
   .REG_W   (REG_W),
   .INSTR_W (INSTR_W)
) u_chk (
   .ex_src1    (ex_src1),
   .ex_src2    (ex_src2),
   .ex_rf_a    (ex_rf_a),
   .ex_rf_b    (ex_rf_b),
   .mem_wr_en  (mem_wr_en),
   .mem_dst    (mem_dst),
   .mem_result (mem_result),
   .wb_instr   (wb_instr),
   .wb_ldata   (wb_ldata),
   .op_a       (op_a),
   .op_b       (op_b),
   .sel_a      (sel_a),
   .sel_b      (sel_b)
);

// File: tb/tb_fwd_operand_select.sv
module tb_fwd_operand_select;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [2:0]  ex_src1, ex_src2, mem_dst;
   logic [15:0] ex_rf_a, ex_rf_b, mem_result, wb_instr, wb_ldata;
   logic        mem_wr_en;
   logic [15:0] op_a, op_b;
   logic [1:0]  sel_a, sel_b;

   fwd_operand_select dut (
      .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
      .mem_wr_en(mem_wr_en), .mem_dst(mem_dst), .mem_result(mem_result),
      .wb_instr(wb_instr), .wb_ldata(wb_ldata),
      .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Behavioural reference: returns code and value for one operand
   function automatic void ref_pick(input int src, input int rf, input bit mw, input int md,
                                    input int mv, input int wop, input int wd, input int wv,
                                    output int code, output int val);
      code = 0; val = rf;
      if (src != 0) begin
         if (mw && md == src) begin code = 1; val = mv; end
         else if (wop == 1 && wd == src) begin code = 2; val = wv; end
      end
   endfunction

   function automatic string tag_of(input int lane, input int src, input int other, input bit mw,
                                    input int md, input int wop, input int wd);
      bit mh = mw && md == src;
      bit wh = wd == src;
      if (src == 0) return "R7";
      if (mh && wop == 1 && wh) return "R6";
      if (mh) return "R5";
      if (wh && wop != 1) return "R4";
      if (wh && src == other) return "R8";
      if (wh) return (lane == 0) ? "R2" : "R3";
      return "R1";
   endfunction

   // Drive one input set after a rising edge, check at the falling edge
   task automatic step(input int s1, input int s2, input int ra, input int rb, input bit mw,
                       input int md, input int mv, input int wop, input int wd, input int wv);
      int ca, va, cb, vb;
      @(posedge clk);
      #1;
      ex_src1 = 3'(s1); ex_src2 = 3'(s2);
      ex_rf_a = 16'(ra); ex_rf_b = 16'(rb);
      mem_wr_en = mw; mem_dst = 3'(md); mem_result = 16'(mv);
      wb_instr = {2'(wop), 3'(wd), 11'(s1 * 97 + 5)};
      wb_ldata = 16'(wv);
      @(negedge clk);
      ref_pick(s1, ra, mw, md, mv, wop, wd, wv, ca, va);
      ref_pick(s2, rb, mw, md, mv, wop, wd, wv, cb, vb);
      check(tag_of(0, s1, s2, mw, md, wop, wd), "sel_a", int'(sel_a), ca);
      check(tag_of(0, s1, s2, mw, md, wop, wd), "op_a",  int'(op_a),  va);
      check(tag_of(1, s2, s1, mw, md, wop, wd), "sel_b", int'(sel_b), cb);
      check(tag_of(1, s2, s1, mw, md, wop, wd), "op_b",  int'(op_b),  vb);
   endtask

   initial begin
      ex_src1 = '0; ex_src2 = '0; ex_rf_a = '0; ex_rf_b = '0;
      mem_wr_en = 1'b0; mem_dst = '0; mem_result = '0; wb_instr = '0; wb_ldata = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset/idle state: register path, R1
      check("R1", "idle sel_a", int'(sel_a), 0);
      check("R1", "idle sel_b", int'(sel_b), 0);
      // R1 plain pass
      step(1, 2, 16'h1234, 16'h5678, 0, 0, 0, 0, 0, 0);
      // R2 load to src1
      step(3, 5, 16'h0101, 16'h0202, 0, 0, 0, 1, 3, 16'hFF80);
      // R3 load to src2 only
      step(4, 5, 16'h0303, 16'h0404, 0, 0, 0, 1, 5, 16'hABCD);
      // R4 non-load opcodes with matching destination
      step(3, 3, 16'h1111, 16'h2222, 0, 0, 0, 0, 3, 16'hDEAD);
      step(3, 6, 16'h1111, 16'h2222, 0, 0, 0, 2, 6, 16'hDEAD);
      step(6, 3, 16'h1111, 16'h2222, 0, 0, 0, 3, 3, 16'hDEAD);
      // R5 memory forward
      step(2, 7, 16'h0A0A, 16'h0B0B, 1, 2, 16'h7777, 0, 0, 0);
      // R6 both stages match, both operands
      step(4, 4, 16'h0C0C, 16'h0D0D, 1, 4, 16'h4444, 1, 4, 16'h9999);
      // R7 register 0 with both stages targeting 0
      step(0, 0, 16'h0E0E, 16'h0F0F, 1, 0, 16'h5555, 1, 0, 16'h6666);
      // R8 shared source forwarded from load
      step(6, 6, 16'h1010, 16'h2020, 0, 0, 0, 1, 6, 16'hC0DE);
      // Random mix with few registers for frequent collisions
      for (int n = 0; n < 400; n++) begin
         step($urandom_range(0, 7), $urandom_range(0, 7), int'($urandom_range(0, 65535)),
              int'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)), $urandom_range(0, 7),
              int'($urandom_range(0, 65535)), $urandom_range(0, 3), $urandom_range(0, 7),
              int'($urandom_range(0, 65535)));
      end
      done = 1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule